// File: doc/BRIEF.md
# General-Purpose Event Status/Enable Register File

This block keeps a word of latched event flags and a word of per-event enables, both reached by software through a byte-wide port window. Hardware sources raise flags with single-cycle pulses, one of them a dedicated hotplug pulse. Software inspects the flags, acknowledges them by writing ones, and chooses which of them may interrupt by programming the enable word. The registered AND of the two words goes to an interrupt aggregator.

Each word spans several byte ports, so software touches one byte at a time. A flag byte uses write-one-to-clear semantics and an enable byte uses plain overwrite. In both cases the other bytes of the word are untouched. When a hardware pulse and a software acknowledge hit the same flag in the same cycle, the flag stays set, so no event is lost. An upstream base decoder supplies a port-select input, and accesses without it are ignored.

Top module: `gpe_regfile`

## Requirements
- R1: Byte offset 0 is the low flag byte, offset 1 the high flag byte, offset 2 the low enable byte and offset 3 the high enable byte (defaults, 16-bit words). A read returns only the selected byte.
- R2: Read data is registered. `rdata` takes the selected byte at the clock edge where `port_sel` and `rd_en` are both high, and otherwise holds its value.
- R3: A write to a flag byte clears each flag bit where the written data holds a one. It never sets a flag and leaves the other flag byte unchanged.
- R4: A write to an enable byte replaces that byte with the written data and leaves the other enable byte unchanged.
- R5: A one on bit k of `evt_set` for one cycle sets flag bit k. A one on `hotplug_pulse` sets flag bit 1.
- R6: If a hardware set and a software clear reach the same flag bit in the same cycle, the bit ends up set. Other bits cleared by that same write are still cleared.
- R7: A read of any offset from 4 upward returns 0xFF. A write to such an offset changes neither word.
- R8: While `port_sel` is low, writes change nothing and reads leave `rdata` unchanged.
- R9: Reset clears the flag word, the enable word, `rdata` and `pending_mask` to zero.
- R10: `pending_mask` equals flags AND enables as they stood one clock earlier. A change made at one edge appears at `pending_mask` after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_sel | input | 1 | Window selected by the upstream base decoder |
| addr | input | ADDR_W | Byte offset inside the window |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data byte |
| evt_set | input | WORD_W | Per-bit hardware event set pulses |
| hotplug_pulse | input | 1 | Hotplug event pulse, sets flag bit 1 |
| pending_mask | output | WORD_W | Registered flags AND enables |

## Verification
The flag word is exercised with a multi-bit event pattern that spans both bytes. Partial acknowledges then show that clearing is per bit and per byte, and a write of all ones to an already clear byte shows that a write never sets a flag. Enable bytes are written one after another with distinct values, which separates a byte-local overwrite from a whole-word write. A combined set-and-clear write, where the set bit is also in the clear data and a second bit is only in the clear data, distinguishes set priority from clear priority and from a dropped write. Out-of-range offsets, deselected accesses and one-cycle sampling of `pending_mask` cover decoding and output timing.

// File: rtl/gpe_pkg.sv
package gpe_pkg;

   localparam int BYTE_W = 8;

   localparam logic [BYTE_W-1:0] UNMAPPED_BYTE = 8'hFF;

   typedef enum logic [1:0] {
      REGION_FLAG   = 2'd0,
      REGION_ENABLE = 2'd1,
      REGION_NONE   = 2'd2
   } region_e;

endpackage

// File: rtl/gpe_port_dec.sv
module gpe_port_dec
   import gpe_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int NBYTES = 2
) (
   input  logic              sel_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   output region_e           region_o,
   output logic [NBYTES-1:0] flag_wr_oh_o,
   output logic [NBYTES-1:0] en_wr_oh_o
);

   localparam int WIN = 2 * NBYTES;

   if (WIN > (1 << ADDR_W)) begin : g_bad_window
      $error("gpe_port_dec: ADDR_W too small for the register window");
   end

   logic [NBYTES-1:0] flag_hit;
   logic [NBYTES-1:0] en_hit;

   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      assign flag_hit[b]     = (addr_i == ADDR_W'(b));
      assign en_hit[b]       = (addr_i == ADDR_W'(NBYTES + b));
      assign flag_wr_oh_o[b] = sel_i & wr_i & flag_hit[b];
      assign en_wr_oh_o[b]   = sel_i & wr_i & en_hit[b];
   end

   always_comb begin
      if (|flag_hit)      region_o = REGION_FLAG;
      else if (|en_hit)   region_o = REGION_ENABLE;
      else                region_o = REGION_NONE;
   end

endmodule

// File: rtl/gpe_status_bank.sv
module gpe_status_bank
   import gpe_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [WORD_W/BYTE_W-1:0] clr_oh_i,
   input  logic [BYTE_W-1:0]        wdata_i,
   input  logic [WORD_W-1:0]        set_i,
   output logic [WORD_W-1:0]        flags_o
);

   localparam int NB = WORD_W / BYTE_W;

   logic [WORD_W-1:0] clr_mask;
   logic [WORD_W-1:0] flags_q;

   for (genvar b = 0; b < NB; b++) begin : g_clr
      assign clr_mask[b*BYTE_W +: BYTE_W] = clr_oh_i[b] ? wdata_i : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (flags_q & ~clr_mask) | set_i;
   end

   assign flags_o = flags_q;

   // R6
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i) |=> ((flags_q & $past(set_i)) == $past(set_i)));

   // R3
   no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(set_i)) == '0));

endmodule

// File: rtl/gpe_enable_bank.sv
module gpe_enable_bank
   import gpe_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [WORD_W/BYTE_W-1:0] wr_oh_i,
   input  logic [BYTE_W-1:0]        wdata_i,
   output logic [WORD_W-1:0]        en_o
);

   localparam int NB = WORD_W / BYTE_W;

   logic [WORD_W-1:0] en_q;

   for (genvar b = 0; b < NB; b++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          en_q[b*BYTE_W +: BYTE_W] <= '0;
         else if (wr_oh_i[b]) en_q[b*BYTE_W +: BYTE_W] <= wdata_i;
      end
   end

   assign en_o = en_q;

   // R4
   enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_oh_i == '0) |=> $stable(en_q));

   // R4
   one_byte_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_oh_i));

endmodule

// File: rtl/gpe_read_mux.sv
module gpe_read_mux
   import gpe_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_stb_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  region_e           region_i,
   input  logic [WORD_W-1:0] flags_i,
   input  logic [WORD_W-1:0] en_i,
   output logic [BYTE_W-1:0] rdata_o
);

   localparam int NB = WORD_W / BYTE_W;
   localparam int WIN = 2 * NB;

   logic [BYTE_W-1:0] flag_byte [NB];
   logic [BYTE_W-1:0] en_byte   [NB];
   logic [BYTE_W-1:0] sel_byte;
   logic [BYTE_W-1:0] rdata_q;

   for (genvar b = 0; b < NB; b++) begin : g_split
      assign flag_byte[b] = flags_i[b*BYTE_W +: BYTE_W];
      assign en_byte[b]   = en_i[b*BYTE_W +: BYTE_W];
   end

   always_comb begin
      sel_byte = UNMAPPED_BYTE;
      for (int b = 0; b < NB; b++) begin
         if (region_i == REGION_FLAG && addr_i == ADDR_W'(b))
            sel_byte = flag_byte[b];
         if (region_i == REGION_ENABLE && addr_i == ADDR_W'(NB + b))
            sel_byte = en_byte[b];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rdata_q <= '0;
      else if (rd_stb_i) rdata_q <= sel_byte;
   end

   assign rdata_o = rdata_q;

   // R7
   oob_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb_i && (32'(addr_i) >= WIN)) |=> (rdata_q == UNMAPPED_BYTE));

   // R2
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb_i |=> $stable(rdata_q));

endmodule

// File: rtl/gpe_regfile.sv
module gpe_regfile
   import gpe_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int ADDR_W = 4,
   parameter int HP_BIT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   input  logic [WORD_W-1:0] evt_set,
   input  logic              hotplug_pulse,
   output logic [WORD_W-1:0] pending_mask
);

   localparam int NB = WORD_W / BYTE_W;

   if (WORD_W % BYTE_W != 0 || WORD_W < BYTE_W) begin : g_bad_width
      $error("gpe_regfile: WORD_W must be a non-zero multiple of 8");
   end
   if (HP_BIT >= WORD_W) begin : g_bad_hp
      $error("gpe_regfile: HP_BIT outside the flag word");
   end

   region_e           region;
   logic [NB-1:0]     flag_wr_oh;
   logic [NB-1:0]     en_wr_oh;
   logic [WORD_W-1:0] hp_vec;
   logic [WORD_W-1:0] set_vec;
   logic [WORD_W-1:0] flags;
   logic [WORD_W-1:0] enables;
   logic [WORD_W-1:0] pending_q;

   always_comb begin
      hp_vec         = '0;
      hp_vec[HP_BIT] = hotplug_pulse;
   end
   assign set_vec = evt_set | hp_vec;

   gpe_port_dec #(.ADDR_W(ADDR_W), .NBYTES(NB)) u_dec (
      .sel_i        (port_sel),
      .wr_i         (wr_en),
      .addr_i       (addr),
      .region_o     (region),
      .flag_wr_oh_o (flag_wr_oh),
      .en_wr_oh_o   (en_wr_oh)
   );

   gpe_status_bank #(.WORD_W(WORD_W)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_oh_i (flag_wr_oh),
      .wdata_i  (wdata),
      .set_i    (set_vec),
      .flags_o  (flags)
   );

   gpe_enable_bank #(.WORD_W(WORD_W)) u_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_oh_i (en_wr_oh),
      .wdata_i (wdata),
      .en_o    (enables)
   );

   gpe_read_mux #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_stb_i (port_sel & rd_en),
      .addr_i   (addr),
      .region_i (region),
      .flags_i  (flags),
      .en_i     (enables),
      .rdata_o  (rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pending_q <= '0;
      else        pending_q <= flags & enables;
   end

   assign pending_mask = pending_q;

   // R10
   pending_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pending_q & ~$past(enables)) == '0));

   // R8
   deselect_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !port_sel |=> ($stable(enables) && ((flags & ~$past(flags)) == (flags & ~$past(flags) & $past(set_vec)))));

   // R5
   hotplug_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hotplug_pulse |=> flags[HP_BIT]);

endmodule

// File: tb/tb_gpe_regfile.sv
module tb_gpe_regfile;

   localparam int WORD_W = 16;
   localparam int ADDR_W = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              port_sel = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic              wr_en = 1'b0;
   logic              rd_en = 1'b0;
   logic [7:0]        wdata = '0;
   logic [7:0]        rdata;
   logic [WORD_W-1:0] evt_set = '0;
   logic              hotplug_pulse = 1'b0;
   logic [WORD_W-1:0] pending_mask;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [WORD_W-1:0] m_flags = '0;
   logic [WORD_W-1:0] m_en = '0;

   always #5 clk = ~clk;

   gpe_regfile #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .HP_BIT(1)) dut (
      .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .addr(addr),
      .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
      .evt_set(evt_set), .hotplug_pulse(hotplug_pulse),
      .pending_mask(pending_mask)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d, input logic sel = 1'b1);
      @(negedge clk);
      port_sel = sel; addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; port_sel = 1'b0;
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d, input logic sel = 1'b1);
      @(negedge clk);
      port_sel = sel; addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0; port_sel = 1'b0;
      d = rdata;
   endtask

   task automatic pulse(input logic [WORD_W-1:0] v, input logic hp);
      @(negedge clk);
      evt_set = v; hotplug_pulse = hp;
      @(negedge clk);
      evt_set = '0; hotplug_pulse = 1'b0;
   endtask

   task automatic chk_all(input string req);
      logic [7:0] d;
      rd(4'd0, d); chk({req, " flag lo"}, 32'(d), 32'(m_flags[7:0]));
      rd(4'd1, d); chk({req, " flag hi"}, 32'(d), 32'(m_flags[15:8]));
      rd(4'd2, d); chk({req, " en lo"},   32'(d), 32'(m_en[7:0]));
      rd(4'd3, d); chk({req, " en hi"},   32'(d), 32'(m_en[15:8]));
   endtask

   task automatic t_reset;
      // R9
      chk("R9 rdata", 32'(rdata), 0);
      chk("R9 pending", 32'(pending_mask), 0);
      chk_all("R9");
   endtask

   task automatic t_enable;
      // R4 R1
      wr(4'd2, 8'hA5); m_en[7:0] = 8'hA5;
      wr(4'd3, 8'h3C); m_en[15:8] = 8'h3C;
      chk_all("R4 R1 enable write");
      wr(4'd2, 8'h0F); m_en[7:0] = 8'h0F;
      chk_all("R4 other byte kept");
   endtask

   task automatic t_flags;
      // R5 R3
      pulse(16'h8421, 1'b0); m_flags |= 16'h8421;
      chk_all("R5 event set");
      wr(4'd0, 8'h01); m_flags[7:0] &= ~8'h01;
      chk_all("R3 partial clear");
      wr(4'd1, 8'hFF); m_flags[15:8] = '0;
      chk_all("R3 high byte clear");
      wr(4'd1, 8'hFF);
      chk_all("R3 write never sets");
   endtask

   task automatic t_hotplug;
      // R5
      pulse('0, 1'b1); m_flags[1] = 1'b1;
      chk_all("R5 hotplug bit 1");
   endtask

   task automatic t_pending;
      // R10
      wr(4'd2, 8'h22); m_en[7:0] = 8'h22;
      chk("R10 pending one cycle later", 32'(pending_mask), 32'(m_flags & {m_en[15:8], 8'h0F}));
      @(negedge clk);
      chk("R10 pending updated", 32'(pending_mask), 32'(m_flags & m_en));
   endtask

   task automatic t_collision;
      // R6
      pulse(16'h0028, 1'b0); m_flags |= 16'h0028;
      @(negedge clk);
      port_sel = 1'b1; addr = 4'd0; wdata = 8'h28; wr_en = 1'b1; evt_set = 16'h0008;
      @(negedge clk);
      wr_en = 1'b0; port_sel = 1'b0; evt_set = '0;
      m_flags = (m_flags & ~16'h0028) | 16'h0008;
      chk_all("R6 set wins over clear");
   endtask

   task automatic t_oob;
      logic [7:0] d;
      // R7
      rd(4'd4, d);  chk("R7 read 4", 32'(d), 32'hFF);
      rd(4'd9, d);  chk("R7 read 9", 32'(d), 32'hFF);
      rd(4'd15, d); chk("R7 read 15", 32'(d), 32'hFF);
      wr(4'd5, 8'hFF);
      wr(4'd4, 8'h00);
      chk_all("R7 write ignored");
   endtask

   task automatic t_deselect;
      logic [7:0] d;
      logic [7:0] held;
      // R8 R2
      rd(4'd2, held);
      chk("R2 read en lo", 32'(held), 32'(m_en[7:0]));
      rd(4'd4, d, 1'b0);
      chk("R8 rdata holds", 32'(d), 32'(held));
      @(negedge clk);
      chk("R2 rdata holds idle", 32'(rdata), 32'(held));
      wr(4'd2, 8'h00, 1'b0);
      wr(4'd0, 8'hFF, 1'b0);
      chk_all("R8 deselected write ignored");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_enable();
      t_flags();
      t_hotplug();
      t_pending();
      t_collision();
      t_oob();
      t_deselect();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule